// File: doc/BRIEF.md
# Dual-Clock Decade Up/Down Counter

This block is a single BCD digit that counts up or down. It has no direction select. Instead it has two count strobes: a rising edge on the up strobe adds one, and a rising edge on the down strobe subtracts one. The value can be forced to zero by a clear, and a parallel load writes any 4-bit value from a preset bus. A preset above nine is accepted, and the counter then walks back into the decimal range along a fixed path.

Two active-low terminal outputs let digits be chained into a multi-digit counter. The carry output falls while the digit sits on nine with the up strobe low. The borrow output falls while the digit sits on zero with the down strobe low. Each stage's carry feeds the next stage's up strobe, and its borrow feeds the next stage's down strobe.

Everything runs on one system clock. The strobes pass through a synchronizer, and their rising edges are detected on that clock. Clear and load are sampled on the system clock edge.

Top module: `bcd_updown_counter`

## Requirements
- R1: When `rst` or `clear` is high at a clock edge, `count` is 0 after that edge, whatever `load_n` and the strobes do.
- R2: When `load_n` is low and `clear` is low at an edge, `count` takes `preset` after that edge, and strobe edges seen while `load_n` is low change nothing.
- R3: A synchronized rising edge on `cnt_up_clk`, while the synchronized `cnt_dn_clk` level is high, adds one to a count of 0 to 8 and turns 9 into 0. The new value appears SYNC_STAGES+1 edges after the first edge that samples the strobe high.
- R4: A synchronized rising edge on `cnt_dn_clk`, while the synchronized `cnt_up_clk` level is high, subtracts one from a count of 1 to 15 and turns 0 into 9.
- R5: Counting up from out-of-range values follows 10→11, 11→6, 12→13, 13→4, 14→15 and 15→2.
- R6: Counting down from 15 steps through 14, 13, 12, 11 and 10 to 9.
- R7: The count does not change when both strobes rise in the same cycle, or when one strobe rises while the other strobe's synchronized level is low.
- R8: `carry_n` is 0 exactly when count bit 0 and bit 3 are both 1 (values 9, 11, 13, 15) and the synchronized up level is low. Otherwise it is 1.
- R9: `borrow_n` is 0 exactly when the count is 0 and the synchronized down level is low. Otherwise it is 1.
- R10: When `carry_n` and `borrow_n` of one stage drive the up and down strobes of a second stage, the second stage counts up once on each 9→0 wrap of the first and down once on each 0→9 wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up_clk | input | 1 | Up strobe, counts on its rising edge |
| cnt_dn_clk | input | 1 | Down strobe, counts on its rising edge |
| load_n | input | 1 | Active-low parallel load |
| preset | input | 4 | Value written by a load |
| clear | input | 1 | Active-high clear to zero |
| count | output | 4 | Current digit value |
| carry_n | output | 1 | Active-low terminal count up |
| borrow_n | output | 1 | Active-low terminal count down |

## Verification
The bench builds the first digit with SYNC_STAGES=2 and a cascaded second digit with SYNC_STAGES=3. This checks that the latency model holds for more than one synchronizer depth. It also checks that carry and borrow pulses from a fast stage are seen correctly by a slower one. Directed stimulus loads every out-of-range value and drives wraps in both directions. It also covers simultaneous strobe edges, strobes raised while the other strobe is low, and clear overriding load.

// File: rtl/bcd_ctr_pkg.sv
package bcd_ctr_pkg;
  localparam int DIGIT_W  = 4;
  localparam int MAX_DIG  = 9;
  typedef logic [DIGIT_W-1:0] digit_t;
  localparam digit_t TOP_DIG = digit_t'(MAX_DIG);
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int   STAGES = 2,
  parameter logic IDLE   = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= {STAGES{IDLE}};
      prev  <= IDLE;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      prev <= chain[STAGES-1];
    end
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~prev;

  // R3
  rise_once_chk: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise);
endmodule

// File: rtl/decade_step.sv
module decade_step
  import bcd_ctr_pkg::*;
(
  input  digit_t cur,
  output digit_t nxt_up,
  output digit_t nxt_dn
);
  always_comb begin
    if (cur < TOP_DIG)       nxt_up = digit_t'(cur + digit_t'(1));
    else if (cur == TOP_DIG) nxt_up = '0;
    else if (cur[0])         nxt_up = digit_t'(5'd17 - {1'b0, cur});
    else                     nxt_up = digit_t'(cur + digit_t'(1));
  end

  always_comb begin
    if (cur == '0) nxt_dn = TOP_DIG;
    else           nxt_dn = digit_t'(cur - digit_t'(1));
  end
endmodule

// File: rtl/bcd_updown_counter.sv
module bcd_updown_counter
  import bcd_ctr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cnt_up_clk,
  input  logic         cnt_dn_clk,
  input  logic         load_n,
  input  logic [3:0]   preset,
  input  logic         clear,
  output logic [3:0]   count,
  output logic         carry_n,
  output logic         borrow_n
);
  logic   up_lvl, up_rise, dn_lvl, dn_rise;
  digit_t cnt_q, step_up, step_dn;
  logic   go_up, go_dn;

  edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_up_sync (
    .clk(clk), .rst(rst), .din(cnt_up_clk), .lvl(up_lvl), .rise(up_rise));

  edge_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_dn_sync (
    .clk(clk), .rst(rst), .din(cnt_dn_clk), .lvl(dn_lvl), .rise(dn_rise));

  decade_step u_step (.cur(cnt_q), .nxt_up(step_up), .nxt_dn(step_dn));

  assign go_up = up_rise & ~dn_rise & dn_lvl;
  assign go_dn = dn_rise & ~up_rise & up_lvl;

  always_ff @(posedge clk) begin
    if (rst || clear)  cnt_q <= '0;
    else if (!load_n)  cnt_q <= preset;
    else if (go_up)    cnt_q <= step_up;
    else if (go_dn)    cnt_q <= step_dn;
  end

  assign count    = cnt_q;
  assign carry_n  = ~(cnt_q[0] & cnt_q[3] & ~up_lvl);
  assign borrow_n = ~((cnt_q == '0) & ~dn_lvl);

  // R1
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> count == 4'd0);
  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load_n) |=> count == $past(preset));
  // R3
  up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && load_n && up_rise && !dn_rise && dn_lvl && count == 4'd9) |=> count == 4'd0);
  // R4
  dn_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && load_n && dn_rise && !up_rise && up_lvl && count == 4'd0) |=> count == 4'd9);
  // R5
  oor_up_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && load_n && up_rise && !dn_rise && dn_lvl && count == 4'd13) |=> count == 4'd4);
  // R6
  oor_dn_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && load_n && dn_rise && !up_rise && up_lvl && count > 4'd9)
    |=> count == digit_t'($past(count) - 4'd1));
  // R7
  both_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && load_n && up_rise && dn_rise) |=> $stable(count));
  // R8
  carry_idle_chk: assert property (@(posedge clk) disable iff (rst)
    up_lvl |-> carry_n);
  // R9
  borrow_idle_chk: assert property (@(posedge clk) disable iff (rst)
    dn_lvl |-> borrow_n);
endmodule

// File: tb/bcd_updown_counter_test.sv
module bcd_updown_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int D0 = 2;
  localparam int D1 = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b1, dn = 1'b1, load_n = 1'b1, clear = 1'b0;
  logic [3:0] preset = 4'd0;
  logic [3:0] count, count_hi;
  logic carry_n, borrow_n, carry_hi, borrow_hi;

  int checks = 0, fails = 0;
  bit started = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_updown_counter #(.SYNC_STAGES(D0)) uut (
    .clk(clk), .rst(rst), .cnt_up_clk(up), .cnt_dn_clk(dn), .load_n(load_n),
    .preset(preset), .clear(clear), .count(count), .carry_n(carry_n), .borrow_n(borrow_n));

  bcd_updown_counter #(.SYNC_STAGES(D1)) uut_hi (
    .clk(clk), .rst(rst), .cnt_up_clk(carry_n), .cnt_dn_clk(borrow_n), .load_n(load_n),
    .preset(preset), .clear(clear), .count(count_hi), .carry_n(carry_hi), .borrow_n(borrow_hi));

  // reference model state per stage
  int m_su[2][4], m_sd[2][4], m_pu[2], m_pd[2], m_cnt[2], m_dep[2];

  function automatic int up_next(int c);
    if (c < 9) return c + 1;
    if (c == 9) return 0;
    case (c)
      10: return 11;  11: return 6;
      12: return 13;  13: return 4;
      14: return 15;  default: return 2;
    endcase
  endfunction

  function automatic int dn_next(int c);
    return (c == 0) ? 9 : c - 1;
  endfunction

  function automatic int m_carry(int s);
    return (((m_cnt[s] % 2) == 1) && (m_cnt[s] >= 8) && (m_su[s][m_dep[s]-1] == 0)) ? 0 : 1;
  endfunction

  function automatic int m_borrow(int s);
    return ((m_cnt[s] == 0) && (m_sd[s][m_dep[s]-1] == 0)) ? 0 : 1;
  endfunction

  always @(posedge clk) begin
    int iu[2], id[2];
    iu[0] = int'(up);  id[0] = int'(dn);
    iu[1] = m_carry(0); id[1] = m_borrow(0);
    for (int s = 0; s < 2; s++) begin
      int ul, dl, ur, dr;
      ul = m_su[s][m_dep[s]-1]; dl = m_sd[s][m_dep[s]-1];
      ur = (ul == 1 && m_pu[s] == 0) ? 1 : 0;
      dr = (dl == 1 && m_pd[s] == 0) ? 1 : 0;
      if (rst) begin
        for (int k = 0; k < 4; k++) begin m_su[s][k] = 1; m_sd[s][k] = 1; end
        m_pu[s] = 1; m_pd[s] = 1; m_cnt[s] = 0;
      end else begin
        if (clear) m_cnt[s] = 0;
        else if (!load_n) m_cnt[s] = int'(preset);
        else if (ur == 1 && dr == 0 && dl == 1) m_cnt[s] = up_next(m_cnt[s]);
        else if (dr == 1 && ur == 0 && ul == 1) m_cnt[s] = dn_next(m_cnt[s]);
        m_pu[s] = ul; m_pd[s] = dl;
        for (int k = 3; k > 0; k--) begin m_su[s][k] = m_su[s][k-1]; m_sd[s][k] = m_sd[s][k-1]; end
        m_su[s][0] = iu[s]; m_sd[s][0] = id[s];
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (int'(count) != m_cnt[0] || int'(carry_n) != m_carry(0) || int'(borrow_n) != m_borrow(0) ||
          int'(count_hi) != m_cnt[1] || int'(carry_hi) != m_carry(1) || int'(borrow_hi) != m_borrow(1)) begin
        fails++;
        $display("FAIL model compare (R3 R4 R5 R6 R7 R8 R9 R10): act %0d/%0d/%0d hi %0d/%0d/%0d exp %0d/%0d/%0d hi %0d/%0d/%0d",
          count, carry_n, borrow_n, count_hi, carry_hi, borrow_hi,
          m_cnt[0], m_carry(0), m_borrow(0), m_cnt[1], m_carry(1), m_borrow(1));
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [3:0] v);
    preset = v; load_n = 1'b0; wait_n(2); load_n = 1'b1; wait_n(2);
  endtask

  task automatic pulse_up();
    up = 1'b0; wait_n(8); up = 1'b1; wait_n(8);
  endtask

  task automatic pulse_dn();
    dn = 1'b0; wait_n(8); dn = 1'b1; wait_n(8);
  endtask

  initial begin
    m_dep[0] = D0; m_dep[1] = D1;
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    rst = 1'b0;
    started = 1'b1;
    wait_n(2);
    chk("R1 reset count", int'(count), 0);
    chk("R9 borrow idle", int'(borrow_n), 1);
    chk("R8 carry idle", int'(carry_n), 1);

    do_load(4'd7);
    chk("R2 load 7", int'(count), 7);
    preset = 4'd3; load_n = 1'b0; wait_n(2);
    up = 1'b0; wait_n(6); up = 1'b1; wait_n(6);
    load_n = 1'b1; wait_n(3);
    chk("R2 edges ignored while loading", int'(count), 3);

    do_load(4'd7);
    pulse_up(); chk("R3 7 to 8", int'(count), 8);
    pulse_up(); chk("R3 8 to 9", int'(count), 9);
    up = 1'b0; wait_n(6);
    chk("R8 carry low at 9", int'(carry_n), 0);
    up = 1'b1; wait_n(8);
    chk("R3 wrap 9 to 0", int'(count), 0);
    chk("R8 carry released", int'(carry_n), 1);

    dn = 1'b0; wait_n(6);
    chk("R9 borrow low at 0", int'(borrow_n), 0);
    dn = 1'b1; wait_n(8);
    chk("R4 wrap 0 to 9", int'(count), 9);
    pulse_dn(); chk("R4 9 to 8", int'(count), 8);

    do_load(4'd10); pulse_up(); chk("R5 10 to 11", int'(count), 11);
    up = 1'b0; wait_n(6); chk("R8 carry low at 11", int'(carry_n), 0);
    up = 1'b1; wait_n(8); chk("R5 11 to 6", int'(count), 6);
    do_load(4'd12); pulse_up(); chk("R5 12 to 13", int'(count), 13);
    pulse_up(); chk("R5 13 to 4", int'(count), 4);
    do_load(4'd14); pulse_up(); chk("R5 14 to 15", int'(count), 15);
    pulse_up(); chk("R5 15 to 2", int'(count), 2);

    do_load(4'd15);
    for (int v = 14; v >= 9; v--) begin
      pulse_dn(); chk("R6 down from out of range", int'(count), v);
    end

    do_load(4'd5);
    up = 1'b0; dn = 1'b0; wait_n(6);
    up = 1'b1; dn = 1'b1; wait_n(8);
    chk("R7 simultaneous edges hold", int'(count), 5);
    up = 1'b0; dn = 1'b0; wait_n(6);
    up = 1'b1; wait_n(8);
    chk("R7 up edge with down low holds", int'(count), 5);
    dn = 1'b1; wait_n(8);
    chk("R4 down edge after hold", int'(count), 4);

    preset = 4'd6; load_n = 1'b0; clear = 1'b1; wait_n(2);
    clear = 1'b0; load_n = 1'b1; wait_n(2);
    chk("R1 clear over load", int'(count), 0);

    do_load(4'd8);
    pulse_up(); pulse_up(); wait_n(4);
    chk("R10 low stage wrapped", int'(count), 0);
    chk("R10 high stage counted up", int'(count_hi), 9);
    pulse_dn(); wait_n(4);
    chk("R10 low stage wrapped down", int'(count), 9);
    chk("R10 high stage counted down", int'(count_hi), 8);

    wait_n(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule